// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands, one multiplier bit per clock, and returns the double-width product split into a high word and a low word. The datapath has a single operand-width adder, a register that holds the multiplicand, and one double-width product register. At the start of an operation the low half of the product register is loaded with the multiplier. Each step examines the least significant bit of that register. When the bit is set, the step adds the multiplicand into the upper half. The whole register, with the adder carry on top, then moves one place to the right. As the multiplier bits are used up, product bits take their place.

A caller raises `start` for one cycle with both operands present. It then waits for the one-cycle `done` pulse and reads `hi` and `lo`. While `busy` is high the block ignores `start` and does not look at its operand inputs. The result stays on the outputs until the next accepted start, and a new start may be given in the same cycle as `done`.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `busy` = 0, `done` = 0, `hi` = 0 and `lo` = 0.
- R2: A `start` sampled high while `busy` is low is accepted. In the next cycle `busy` is 1.
- R3: On the `done` cycle, {`hi`,`lo`} is the exact unsigned 2*WIDTH-bit product of the `op_a` and `op_b` values sampled with the accepted start. The adder carry is kept, so all-ones times all-ones is exact.
- R4: `busy` stays high for exactly WIDTH cycles. `done` is high in the cycle after the (WIDTH+1)-th rising edge, counting the edge that accepted the start as the first.
- R5: `done` is a single-cycle pulse and is never high together with `busy`.
- R6: A `start` sampled while `busy` is high has no effect: the running result and its timing are unchanged, and no extra `done` appears.
- R7: `hi` and `lo` hold their final values after `done` until the next accepted start.
- R8: A `start` given in the `done` cycle is accepted, so operations can follow one another with no idle gap.
- R9: `op_a` and `op_b` are only sampled on the accepted-start edge. Changing them while `busy` is high does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| hi | output | WIDTH | Upper half of the product |
| lo | output | WIDTH | Lower half of the product |

## Verification
Each accepted operation puts its expected product and the cycle number of its request into a scoreboard queue. The monitor expects `done` exactly 33 rising edges after the falling edge on which `start` was driven. It compares the product and that latency when `done` rises, and samples only on falling edges, so every register update has settled. `busy` is checked on the falling edge right after the accepting edge. Held outputs are read several falling edges after `done`. Starts driven during a run and operands changed during a run must leave the queued result and its arrival cycle unchanged.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sam_state_e;

endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [WIDTH:0] carry;
            assign carry[0] = 1'b0;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign sum[i]     = x[i] ^ y[i] ^ carry[i];
                assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
            end
            assign cout = carry[WIDTH];
        end else begin : g_behav
            logic [WIDTH:0] full;
            assign full = {1'b0, x} + {1'b0, y};
            assign sum  = full[WIDTH-1:0];
            assign cout = full[WIDTH];
        end
    endgenerate

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
    import sam_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        sam_state_e       state;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        step = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_FIN: begin
                if (start) begin
                    load      = 1'b1;
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_RUN: begin
                step    = 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.state = ST_FIN;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state == ST_RUN);
    assign done = (r_q.state == ST_FIN);

endmodule

// File: rtl/sam_dpath.sv
module sam_dpath #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);

    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] mcand;
        logic [PW-1:0]    prod;
    } dp_t;

    dp_t r_d, r_q;

    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] upper_sum;
    logic             upper_cout;

    assign addend = r_q.prod[0] ? r_q.mcand : '0;

    sam_adder #(
        .WIDTH (WIDTH),
        .RIPPLE(RIPPLE)
    ) u_add (
        .x   (r_q.prod[PW-1:WIDTH]),
        .y   (addend),
        .sum (upper_sum),
        .cout(upper_cout)
    );

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.mcand = mcand_in;
            r_d.prod  = {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            r_d.prod = {upper_cout, upper_sum, r_q.prod[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prod = r_q.prod;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);

    logic               load;
    logic               step;
    logic [2*WIDTH-1:0] prod;

    sam_ctrl #(
        .WIDTH(WIDTH)
    ) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    sam_dpath #(
        .WIDTH (WIDTH),
        .RIPPLE(RIPPLE)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .mcand_in (op_a),
        .mplier_in(op_b),
        .prod     (prod)
    );

    assign hi = prod[2*WIDTH-1:WIDTH];
    assign lo = prod[WIDTH-1:0];

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);

    logic [WIDTH-1:0] ref_a, ref_b;
    int unsigned      run_cnt;
    logic             accept;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_a   <= '0;
            ref_b   <= '0;
            run_cnt <= 0;
        end else if (accept) begin
            ref_a   <= op_a;
            ref_b   <= op_b;
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R1: outputs idle while reset is applied
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && hi == '0 && lo == '0));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    assert_product_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ({hi, lo} == ({{WIDTH{1'b0}}, ref_a} * {{WIDTH{1'b0}}, ref_b})));

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == WIDTH));

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ignore_start_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(hi) && $stable(lo)));

endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .op_a (op_a),
    .op_b (op_b),
    .busy (busy),
    .done (done),
    .hi   (hi),
    .lo   (lo)
);

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;

    localparam int W   = 32;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int unsigned  cyc = 0;
    int           n_chk = 0;
    int           n_fail = 0;
    logic [2*W-1:0] exp_q[$];
    int unsigned    when_q[$];
    logic [2*W-1:0] last_exp = '0;
    bit             prev_done = 1'b0;
    bit             wd = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_add_mul #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && done) chk(1'b0, "R5 busy&done", {62'd0, busy, done}, 64'd1);
            if (done && prev_done) chk(1'b0, "R5 pulse", 64'd1, 64'd0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", {hi, lo}, 64'd0);
                end else begin
                    logic [2*W-1:0] e;
                    int unsigned    c0;
                    e  = exp_q.pop_front();
                    c0 = when_q.pop_front();
                    chk({hi, lo} == e, "R3 product", {hi, lo}, e);
                    chk(cyc == c0 + LAT, "R4 latency", 64'(cyc - c0), 64'(LAT));
                end
            end
            prev_done = done;
        end
    end

    task automatic issue(input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1;
        op_a  = x;
        op_b  = y;
        last_exp = {{W{1'b0}}, x} * {{W{1'b0}}, y};
        exp_q.push_back(last_exp);
        when_q.push_back(cyc);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", {63'd0, busy}, 64'd1);
        // R9: scramble operands while running
        op_a = $urandom;
        op_b = $urandom;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_tests();
        repeat (4) @(negedge clk);
        chk(!busy && !done && hi == '0 && lo == '0, "R1 reset state",
            {hi, lo}, 64'd0);
        rst = 1'b0;

        issue(32'd2, 32'd3);                 drain();
        issue(32'd0, 32'd0);                 drain();
        issue(32'd0, 32'hDEAD_BEEF);         drain();
        issue(32'h1234_5678, 32'd0);         drain();
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF); drain();
        issue(32'h8000_0000, 32'h8000_0000); drain();
        issue(32'd1, 32'hCAFE_F00D);         drain();
        for (int k = 0; k < W; k += 7) begin
            issue(W'(1) << k, W'(1) << (W - 1 - k)); drain();
        end

        // R7: outputs hold after done
        repeat (6) @(negedge clk);
        chk({hi, lo} == last_exp, "R7 hold", {hi, lo}, last_exp);

        // R6: start pulses during a run are ignored
        issue(32'h0F0F_0F0F, 32'h0000_1001);
        for (int i = 0; i < 4; i++) begin
            start = 1'b1;
            op_a  = $urandom;
            op_b  = $urandom;
            @(negedge clk);
        end
        start = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        chk({hi, lo} == last_exp, "R6 ignored start", {hi, lo}, last_exp);

        // R8: back-to-back operations, second issued in the done cycle
        issue(32'hFFFF_0000, 32'h0001_FFFF);
        issue(32'h7654_3210, 32'h89AB_CDEF);
        issue(32'hFFFF_FFFF, 32'd2);
        drain();

        for (int i = 0; i < 12; i++) begin
            issue($urandom, $urandom);
            drain();
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule